// File: doc/BRIEF.md
# Single-Precision to Integer Saturating Converter

This block turns a 32-bit binary floating-point operand into an integer. A two-bit mode picks one of four targets: 32-bit or 64-bit, signed or unsigned. The fraction is always dropped toward zero. A start pulse loads the operand and the mode. One clock later the block presents a 64-bit result and two exception flags: `invalid` and `inexact`.

Some operands have no meaningful integer value. These are NaN, values outside the target range, and negative values whose integer part is nonzero when the target is unsigned. For each of these the block returns a fixed saturation value, raises `invalid` and holds `inexact` low. For 32-bit targets the 64-bit result port carries the low word sign-extended. This holds for the unsigned 32-bit mode too.

Top module: `f2i_sat_conv`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `start_i` high, and low otherwise. Result and flags change only after a start.
- R2: Mode 0 selects signed 32-bit, mode 1 unsigned 32-bit, mode 2 signed 64-bit and mode 3 unsigned 64-bit. In-range operands give the value truncated toward zero, for example 2.5 gives 2 and -2.5 gives -2.
- R3: For an in-range operand, `inexact_o` is 1 exactly when the discarded fraction is nonzero. Subnormals are included, and give 0 with inexact.
- R4: A NaN operand (quiet or signalling) in a signed mode gives the largest positive value of the target width, with invalid. That value is 0x7FFFFFFF for 32-bit and 0x7FFF_FFFF_FFFF_FFFF for 64-bit.
- R5: A NaN operand in an unsigned mode gives all ones, with invalid.
- R6: In an unsigned mode, a negative operand whose integer part is nonzero gives 0 with invalid. Negative infinity is included.
- R7: In an unsigned mode, a negative operand that truncates to zero gives 0 without invalid, for example -0.5. It sets inexact only if a fraction was dropped, so -0.0 raises no flag.
- R8: In a signed mode, a magnitude outside the target range saturates and raises invalid. A negative operand goes to the minimum value and a positive one to the maximum. Infinities are included. The exact minimum (-2^31 or -2^63) is in range.
- R9: In an unsigned mode, a positive value at or above 2^32 or 2^64 gives all ones with invalid. Positive infinity is included.
- R10: Whenever invalid is raised, inexact is 0, for example -1.5 in an unsigned mode.
- R11: In both 32-bit modes, bits 63:32 of the result copy bit 31. For example, unsigned 2^31 reads 0xFFFF_FFFF_8000_0000.
- R12: After reset, `valid_o`, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load operand and mode this cycle |
| mode_i | input | 2 | Target format (see R2) |
| operand_i | input | 32 | Single-precision operand |
| valid_o | output | 1 | Result valid, one cycle after start |
| result_o | output | 64 | Converted or saturated integer |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The assertions assume that `mode_i` and `operand_i` are meaningful in any cycle where `start_i` is high. They make no assumption about the inputs in other cycles. The assertions look at the converter's internal events in the start cycle: NaN detection, fraction loss and negative-to-unsigned detection. They then check the registered flags and result in the next cycle.

The bench drives every operand together with a start pulse. It mixes back-to-back starts with idle gaps. It uses ordinary, subnormal, zero, infinite, NaN and exact power-of-two boundary values in each mode.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [1:0] {
    CVT_S32 = 2'd0,
    CVT_U32 = 2'd1,
    CVT_S64 = 2'd2,
    CVT_U64 = 2'd3
  } cvt_mode_e;

  function automatic logic mode_is_unsigned(cvt_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_is_wide(cvt_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FLT_W = EXP_W + MAN_W + 1,
  localparam int E_W   = EXP_W + 2
) (
  input  logic [FLT_W-1:0]     op_i,
  output logic                 neg_o,
  output logic                 nan_o,
  output logic signed [E_W-1:0] exp_o,
  output logic [MAN_W:0]       mant_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] frac;
  logic [EXP_W-1:0] expf_eff;
  logic             hidden;

  assign expf   = op_i[FLT_W-2 -: EXP_W];
  assign frac   = op_i[MAN_W-1:0];
  assign neg_o  = op_i[FLT_W-1];
  assign nan_o  = (&expf) && (|frac);
  assign hidden = |expf;
  // subnormals share the smallest normal exponent, without the hidden bit
  assign expf_eff = hidden ? expf : EXP_W'(1);
  assign exp_o  = $signed(E_W'(expf_eff) - E_W'(BIAS));
  assign mant_o = {hidden, frac};
endmodule

// File: rtl/f2i_truncate.sv
module f2i_truncate #(
  parameter int MAN_W = 23,
  parameter int INT_W = 64,
  parameter int E_W   = 10
) (
  input  logic signed [E_W-1:0] exp_i,
  input  logic [MAN_W:0]        mant_i,
  output logic [INT_W-1:0]      mag_o,
  output logic                  frac_nz_o,
  output logic                  huge_o
);
  function automatic logic [INT_W-1:0] low_mask(int sh);
    return ~({INT_W{1'b1}} << sh);
  endfunction

  logic [INT_W-1:0] ext;
  int               e_int;
  int               sh;

  assign ext = INT_W'(mant_i);

  always_comb begin
    e_int     = int'(exp_i);
    sh        = 0;
    mag_o     = '0;
    frac_nz_o = 1'b0;
    huge_o    = 1'b0;
    if (e_int < 0) begin
      frac_nz_o = |mant_i;
    end else if (e_int >= INT_W) begin
      huge_o = 1'b1;
    end else if (e_int >= MAN_W) begin
      mag_o = ext << (e_int - MAN_W);
    end else begin
      sh        = MAN_W - e_int;
      mag_o     = ext >> sh;
      frac_nz_o = |(ext & low_mask(sh));
    end
  end
endmodule

// File: rtl/f2i_saturate.sv
module f2i_saturate
  import f2i_pkg::*;
#(
  parameter int INT_W = 64,
  localparam int HALF_W = INT_W / 2
) (
  input  cvt_mode_e        mode_i,
  input  logic             neg_i,
  input  logic             nan_i,
  input  logic             huge_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             frac_nz_i,
  output logic             neg_to_uns_o,
  output logic             ovf_o,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  // 2^(w-1) for the selected target width w
  function automatic logic [INT_W-1:0] sign_weight(logic wide);
    return {{(INT_W-1){1'b0}}, 1'b1} << (wide ? INT_W - 1 : HALF_W - 1);
  endfunction

  function automatic logic [INT_W-1:0] narrow_sext(logic [INT_W-1:0] v);
    return {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  logic             uns;
  logic             wide;
  logic [INT_W-1:0] lim;
  logic             hi_nz;
  logic             raw_ovf;
  logic [INT_W-1:0] raw;

  assign uns   = mode_is_unsigned(mode_i);
  assign wide  = mode_is_wide(mode_i);
  assign lim   = sign_weight(wide);
  assign hi_nz = |mag_i[INT_W-1:HALF_W];

  assign neg_to_uns_o = !nan_i && uns && neg_i && (huge_i || (|mag_i));

  always_comb begin
    if (uns)        raw_ovf = !neg_i && (huge_i || (!wide && hi_nz));
    else if (neg_i) raw_ovf = huge_i || (mag_i > lim);
    else            raw_ovf = huge_i || (mag_i >= lim);
  end
  assign ovf_o = !nan_i && !neg_to_uns_o && raw_ovf;

  always_comb begin
    if (nan_i)             raw = uns ? {INT_W{1'b1}} : lim - 1'b1;
    else if (neg_to_uns_o) raw = '0;
    else if (ovf_o)        raw = uns ? {INT_W{1'b1}} : (neg_i ? (~lim + 1'b1) : lim - 1'b1);
    else if (neg_i)        raw = ~mag_i + 1'b1;
    else                   raw = mag_i;
  end

  assign res_o     = wide ? raw : narrow_sext(raw);
  assign invalid_o = nan_i || neg_to_uns_o || ovf_o;
  assign inexact_o = frac_nz_i && !invalid_o;
endmodule

// File: rtl/f2i_sat_conv.sv
module f2i_sat_conv
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 64,
  localparam int FLT_W  = EXP_W + MAN_W + 1,
  localparam int E_W    = EXP_W + 2,
  localparam int HALF_W = INT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [FLT_W-1:0] operand_i,
  output logic             valid_o,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  cvt_mode_e               mode_w;
  logic                    neg_w;
  logic                    nan_w;
  logic signed [E_W-1:0]   exp_w;
  logic [MAN_W:0]          mant_w;
  logic [INT_W-1:0]        mag_w;
  logic                    frac_nz_w;
  logic                    huge_w;
  logic                    neg_to_uns_w;
  logic                    ovf_w;
  logic [INT_W-1:0]        res_w;
  logic                    inv_w;
  logic                    inx_w;

  logic                    valid_q;
  logic [INT_W-1:0]        result_q;
  logic                    inv_q;
  logic                    inx_q;
  logic                    narrow_q;

  assign mode_w = cvt_mode_e'(mode_i);

  f2i_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .op_i   (operand_i),
    .neg_o  (neg_w),
    .nan_o  (nan_w),
    .exp_o  (exp_w),
    .mant_o (mant_w)
  );

  f2i_truncate #(.MAN_W(MAN_W), .INT_W(INT_W), .E_W(E_W)) u_truncate (
    .exp_i     (exp_w),
    .mant_i    (mant_w),
    .mag_o     (mag_w),
    .frac_nz_o (frac_nz_w),
    .huge_o    (huge_w)
  );

  f2i_saturate #(.INT_W(INT_W)) u_saturate (
    .mode_i       (mode_w),
    .neg_i        (neg_w),
    .nan_i        (nan_w),
    .huge_i       (huge_w),
    .mag_i        (mag_w),
    .frac_nz_i    (frac_nz_w),
    .neg_to_uns_o (neg_to_uns_w),
    .ovf_o        (ovf_w),
    .res_o        (res_w),
    .invalid_o    (inv_w),
    .inexact_o    (inx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      inv_q    <= 1'b0;
      inx_q    <= 1'b0;
      narrow_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) begin
        result_q <= res_w;
        inv_q    <= inv_w;
        inx_q    <= inx_w;
        narrow_q <= !mode_is_wide(mode_w);
      end
    end
  end

  assign valid_o   = valid_q;
  assign result_o  = result_q;
  assign invalid_o = inv_q;
  assign inexact_o = inx_q;

  // R1
  valid_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  // R10
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(invalid_o && inexact_o));
  // R11
  narrow_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && narrow_q) |-> (result_o[INT_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}}));
  // R6
  neg_uns_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && neg_to_uns_w) |=> (result_o == '0 && invalid_o));
  // R3
  exact_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !frac_nz_w) |=> !inexact_o);
  // R4
  nan_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && nan_w) |=> (invalid_o && result_o[HALF_W-2:0] == {(HALF_W-1){1'b1}}));
  // R8
  ovf_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ovf_w) |=> invalid_o);
endmodule

// File: tb/f2i_sat_conv_tb_top.sv
`timescale 1ns/1ps
module f2i_sat_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] op = '0;
  logic        valid;
  logic [63:0] res;
  logic        inv;
  logic        inx;

  always #4 clk = ~clk;

  f2i_sat_conv dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .mode_i    (mode),
    .operand_i (op),
    .valid_o   (valid),
    .result_o  (res),
    .invalid_o (inv),
    .inexact_o (inx)
  );

  typedef struct packed {
    logic [63:0] r;
    logic        i;
    logic        x;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    ended  = 1'b0;

  localparam logic [1:0] S32 = 2'd0, U32 = 2'd1, S64 = 2'd2, U64 = 2'd3;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic note(string tag, bit ok, string act, string expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic drive(string tag, logic [1:0] m, logic [31:0] f,
                       logic [63:0] r, logic i, logic x);
    item_t it;
    @(negedge clk);
    start = 1'b1;
    mode  = m;
    op    = f;
    it    = '{r: r, i: i, x: x};
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      start = 1'b0;
      op    = 32'hDEAD_BEEF;
    end
  endtask

  // bit pattern of (k + 0.5), k small positive
  function automatic logic [31:0] half_plus(int k, bit neg);
    logic [31:0] v2;
    int          p;
    logic [31:0] body;
    v2 = 32'(2 * k + 1);
    p  = 0;
    for (int b = 0; b < 24; b++) if (v2[b]) p = b;
    body = v2 << (23 - p);
    return {neg, 8'(126 + p), body[22:0]};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    item_t e;
    string t;
    if (rst_n && valid && !ended) begin
      if (exp_q.size() == 0) begin
        note("R1", 1'b0, "valid with nothing pending", "no valid");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        note(t, (res === e.r) && (inv === e.i) && (inx === e.x),
             $sformatf("%h inv=%0b inx=%0b", res, inv, inx),
             $sformatf("%h inv=%0b inx=%0b", e.r, e.i, e.x));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    note("R12", valid === 1'b0 && res === 64'd0 && inv === 1'b0 && inx === 1'b0,
         $sformatf("v=%0b %h %0b %0b", valid, res, inv, inx), "v=0 0 0 0");

    // R2 / R3 basic truncation
    drive("R2 1.0 s32",    S32, 32'h3F80_0000, 64'd1, 0, 0);
    drive("R2 2.5 s32",    S32, 32'h4020_0000, 64'd2, 0, 1);
    drive("R2 -2.5 s32",   S32, 32'hC020_0000, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1);
    drive("R2 -2.5 s64",   S64, 32'hC020_0000, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1);
    drive("R3 1.75 u32",   U32, 32'h3FE0_0000, 64'd1, 0, 1);
    drive("R3 123456.75",  S64, 32'h47F1_2060, 64'd123456, 0, 1);
    drive("R3 subnormal",  S32, 32'h0000_0001, 64'd0, 0, 1);
    drive("R3 -subnormal", S32, 32'h8000_0001, 64'd0, 0, 1);
    drive("R2 +0 u64",     U64, 32'h0000_0000, 64'd0, 0, 0);
    idle(2);
    // R1 no valid during idle
    note("R1", valid === 1'b0, $sformatf("valid=%0b", valid), "valid=0");

    // R4 / R5 NaN
    drive("R4 qNaN s32",   S32, 32'h7FC0_0000, 64'h0000_0000_7FFF_FFFF, 1, 0);
    drive("R4 sNaN s64",   S64, 32'h7F80_0001, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0);
    drive("R4 -NaN s32",   S32, 32'hFFC0_0000, 64'h0000_0000_7FFF_FFFF, 1, 0);
    drive("R5 qNaN u32",   U32, 32'h7FC0_0000, ONES, 1, 0);
    drive("R5 NaN u64",    U64, 32'hFFC0_0001, ONES, 1, 0);

    // R6 / R7 / R10 negatives into unsigned
    drive("R6 -1.0 u32",   U32, 32'hBF80_0000, 64'd0, 1, 0);
    drive("R6 -inf u32",   U32, 32'hFF80_0000, 64'd0, 1, 0);
    drive("R10 -1.5 u64",  U64, 32'hBFC0_0000, 64'd0, 1, 0);
    drive("R7 -0.5 u32",   U32, 32'hBF00_0000, 64'd0, 0, 1);
    drive("R7 -0.0 u64",   U64, 32'h8000_0000, 64'd0, 0, 0);
    idle(1);

    // R8 signed range
    drive("R8 2^31 s32",   S32, 32'h4F00_0000, 64'h0000_0000_7FFF_FFFF, 1, 0);
    drive("R8 -2^31 s32",  S32, 32'hCF00_0000, 64'hFFFF_FFFF_8000_0000, 0, 0);
    drive("R8 -2^32 s32",  S32, 32'hCF80_0000, 64'hFFFF_FFFF_8000_0000, 1, 0);
    drive("R8 +inf s32",   S32, 32'h7F80_0000, 64'h0000_0000_7FFF_FFFF, 1, 0);
    drive("R8 -inf s64",   S64, 32'hFF80_0000, 64'h8000_0000_0000_0000, 1, 0);
    drive("R8 2^63 s64",   S64, 32'h5F00_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0);
    drive("R8 -2^63 s64",  S64, 32'hDF00_0000, 64'h8000_0000_0000_0000, 0, 0);
    drive("R8 -2^31 s64",  S64, 32'hCF00_0000, 64'hFFFF_FFFF_8000_0000, 0, 0);

    // R9 unsigned range
    drive("R9 2^32 u32",   U32, 32'h4F80_0000, ONES, 1, 0);
    drive("R9 2^32 u64",   U64, 32'h4F80_0000, 64'h0000_0001_0000_0000, 0, 0);
    drive("R9 2^63 u64",   U64, 32'h5F00_0000, 64'h8000_0000_0000_0000, 0, 0);
    drive("R9 2^64 u64",   U64, 32'h5F80_0000, ONES, 1, 0);
    drive("R9 +inf u64",   U64, 32'h7F80_0000, ONES, 1, 0);

    // R11 sign extension in 32-bit unsigned
    drive("R11 2^31 u32",  U32, 32'h4F00_0000, 64'hFFFF_FFFF_8000_0000, 0, 0);
    drive("R11 max u32",   U32, 32'h4F7F_FFFF, 64'hFFFF_FFFF_FFFF_FF00, 0, 0);
    idle(1);

    // R2 / R3 sweep of k + 0.5
    for (int k = 1; k <= 20; k++) begin
      drive("R3 sweep s64", S64, half_plus(k, 1'b0), 64'(k), 0, 1);
      drive("R2 sweep s32", S32, half_plus(k, 1'b1), -64'(k), 0, 1);
    end
    idle(4);
    note("R1", exp_q.size() == 0 && valid === 1'b0,
         $sformatf("pending=%0d valid=%0b", exp_q.size(), valid), "pending=0 valid=0");
    report();
  end
endmodule